// File: doc/BRIEF.md
# PWM Dead-Time Inserter

This block turns one PWM waveform into a pair of complementary gate-drive lines that are never high together. Each edge of the incoming PWM line first pulls both drive lines low. A down-counter loaded from an 8-bit setting then holds them low for that many clock cycles. When the count ends, the line that matches the present PWM level is switched on. A rising PWM edge therefore ends in the true line high, and a falling edge ends in the complementary line high.

A PWM pulse that does not outlast the dead band is removed entirely. No short sliver reaches either output, and the counter restarts from the newer edge. A setting of zero makes the block a plain one-register pass-through with an inverted partner. A kill input forces both lines low. A mode bit chooses whether kill acts on the outputs at once, without waiting for a clock, or only from the next clock edge. Both outputs stay low after kill is released until a fresh PWM edge has completed a whole dead band. The PWM input is assumed to be synchronous to the block clock, and the block runs on that clock with no prescaler.

Top module: `pwm_dtu`

## Requirements
- R1: While reset is asserted and after it is released, `drv_hi`, `drv_lo` and `busy` are 0. They stay 0 until a PWM edge arrives.
- R2: If `pwm_in` is sampled high at clock edge t0, having been low at the previous edge, and the setting is D, then `drv_hi` and `drv_lo` are 0 after edges t0 through t(D-1), and `drv_hi` is 1 after edge tD. D may be any value from 0 to 255.
- R3: A falling PWM edge behaves like R2 with the roles swapped. `drv_lo` goes to 1 after edge tD, and `drv_hi` stays 0.
- R4: With a setting of 0, after the first PWM edge, `drv_hi` equals `pwm_in` as sampled at the previous clock edge, and `drv_lo` is its inverse.
- R5: A PWM pulse W cycles wide with W <= D never sets the output that its level selects. The other output stays low for W + D cycles, counted from the pulse's first edge.
- R6: A PWM pulse W cycles wide with W > D drives its output high for exactly W - D cycles.
- R7: `drv_hi` and `drv_lo` are never 1 at the same time.
- R8: `busy` is 1 for exactly D cycles after a PWM edge with setting D, and 0 when no dead band is running.
- R9: With `kill_async` = 0, a `kill_req` sampled at a clock edge forces both outputs to 0 from that edge onward. The outputs do not change before that edge.
- R10: With `kill_async` = 1, `kill_req` = 1 forces both outputs to 0 at once, without waiting for a clock edge.
- R11: After kill is released, both outputs stay 0 until a new PWM edge is followed by a complete dead band.
- R12: The setting is captured at the PWM edge. Changing it while a dead band runs does not change the length of that band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the dead-band counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_in | input | 1 | PWM line, synchronous to clk |
| dead_cfg | input | DT_W (8) | Dead-band length in clock cycles |
| kill_req | input | 1 | Request to force both drive lines low |
| kill_async | input | 1 | 1: kill acts immediately; 0: kill acts from the next clock edge |
| drv_hi | output | 1 | True gate-drive line |
| drv_lo | output | 1 | Complementary gate-drive line |
| busy | output | 1 | High while the dead-band counter is running |

## Verification
A counter that loads the wrong value or stops on the wrong count shows up at the first edge it handles. The low gap on the drive lines is one cycle too long or too short, and `busy` shows the same error, so the bench counts both cycle by cycle for settings 0, 1 and 255. A stale level register, or a lost edge, turns on the wrong drive line one band after the edge. It may also let a swallowed pulse leak through. The pulse tests catch both within a few cycles. Kill state that is not cleared becomes visible right after release. Any output that comes back high before a new edge and a full band breaks the resume check in the next sampled cycle.

// File: rtl/pwm_dtu_pkg.sv
package pwm_dtu_pkg;
  localparam int unsigned DT_W       = 8;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_HI  = 2'b01,
    DRV_LO  = 2'b10
  } drv_e;
endpackage

// File: rtl/pwm_dtu_rst_sync.sv
module pwm_dtu_rst_sync #(
  parameter int unsigned STAGES = pwm_dtu_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_dtu_edge.sv
module pwm_dtu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic pwm_q,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_in;
  end

  assign rise = pwm_in & ~pwm_q;
  assign fall = ~pwm_in & pwm_q;
endmodule

// File: rtl/pwm_dtu_band_cnt.sv
module pwm_dtu_band_cnt #(
  parameter int unsigned DT_W = pwm_dtu_pkg::DT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [DT_W-1:0] cfg,
  output logic            busy,
  output logic            expire
);
  localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = cfg;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == ONE) & ~load & ~clr;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> cnt_q == $past(cfg)); // R12

  AST_BAND_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load && !clr |=> (cnt_q + ONE) == $past(cnt_q)); // R8
endmodule

// File: rtl/pwm_dtu_drive.sv
module pwm_dtu_drive
  import pwm_dtu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill_now,
  input  logic rise,
  input  logic fall,
  input  logic cfg_zero,
  input  logic expire,
  input  logic level,
  output drv_e state_q
);
  drv_e state_d;
  logic state_en;

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    if (kill_now) begin
      state_d  = DRV_OFF;
      state_en = 1'b1;
    end else if (rise || fall) begin
      state_en = 1'b1;
      if (cfg_zero) state_d = rise ? DRV_HI : DRV_LO;
      else          state_d = DRV_OFF;
    end else if (expire) begin
      state_en = 1'b1;
      state_d  = level ? DRV_HI : DRV_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= DRV_OFF;
    else if (state_en) state_q <= state_d;
  end

  AST_EDGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) && !cfg_zero && !kill_now |=> state_q == DRV_OFF); // R2

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rise && cfg_zero && !kill_now |=> state_q == DRV_HI); // R4

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill_now |=> state_q == DRV_OFF); // R9

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == DRV_OFF && !rise && !fall && !expire |=> state_q == DRV_OFF); // R11
endmodule

// File: rtl/pwm_dtu.sv
module pwm_dtu
  import pwm_dtu_pkg::*;
#(
  parameter int unsigned DT_W = pwm_dtu_pkg::DT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dead_cfg,
  input  logic            kill_req,
  input  logic            kill_async,
  output logic            drv_hi,
  output logic            drv_lo,
  output logic            busy
);
  logic rst_sync_n;
  logic pwm_q, rise, fall;
  logic expire;
  logic kill_q, kill_now;
  drv_e state_q;

  pwm_dtu_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pwm_dtu_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pwm_in (pwm_in),
    .pwm_q  (pwm_q),
    .rise   (rise),
    .fall   (fall)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) kill_q <= 1'b0;
    else             kill_q <= kill_req;
  end

  assign kill_now = kill_async ? kill_req : kill_q;

  pwm_dtu_band_cnt #(.DT_W(DT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (kill_now),
    .load   (rise | fall),
    .cfg    (dead_cfg),
    .busy   (busy),
    .expire (expire)
  );

  pwm_dtu_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .kill_now (kill_now),
    .rise     (rise),
    .fall     (fall),
    .cfg_zero (dead_cfg == '0),
    .expire   (expire),
    .level    (pwm_q),
    .state_q  (state_q)
  );

  assign drv_hi = (state_q == DRV_HI) & ~kill_now;
  assign drv_lo = (state_q == DRV_LO) & ~kill_now;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(drv_hi && drv_lo)); // R7

  AST_SYNC_KILL_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kill_req && !kill_async |=> !drv_hi && !drv_lo); // R9
endmodule

// File: tb/tb_pwm_dtu.sv
`timescale 1ns/1ps
module tb_pwm_dtu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic [7:0] dead_cfg;
  logic       kill_req;
  logic       kill_async;
  logic       drv_hi, drv_lo, busy;

  int total = 0;
  int bad = 0;
  int overlaps = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  pwm_dtu dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dead_cfg(dead_cfg),
    .kill_req(kill_req), .kill_async(kill_async),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .busy(busy)
  );

  always @(negedge clk) if (drv_hi && drv_lo) overlaps++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_in = 1'b0; dead_cfg = 8'd3; kill_req = 1'b0; kill_async = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset hi", drv_hi, 0);
    chk("R1 reset lo", drv_lo, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1'b1;
    begin
      int ones = 0;
      repeat (8) begin
        @(negedge clk);
        ones += drv_hi + drv_lo + busy;
      end
      chk("R1 idle after release", ones, 0);
    end
  endtask

  // rising edge with setting d; cfg_after is applied after the first sample (R12)
  task automatic gap_rise(input int d, input int cfg_after, input string req);
    int lows = 0; int busys = 0; int lo_on = 0; bit seen = 0;
    @(negedge clk);
    dead_cfg = d[7:0];
    pwm_in = 1'b1;
    for (int k = 0; k < d + 3; k++) begin
      @(negedge clk);
      if (!seen && !drv_hi) lows++;
      if (drv_hi) seen = 1;
      if (busy) busys++;
      if (drv_lo) lo_on++;
      if (k == 0 && cfg_after >= 0) dead_cfg = cfg_after[7:0];
    end
    chk({req, " rise gap"}, lows, d);
    chk({req, " rise lo stays off"}, lo_on, 0);
    chk("R8 busy length rise", busys, d);
  endtask

  task automatic gap_fall(input int d, input string req);
    int lows = 0; int busys = 0; int hi_on = 0; bit seen = 0;
    @(negedge clk);
    dead_cfg = d[7:0];
    pwm_in = 1'b0;
    for (int k = 0; k < d + 3; k++) begin
      @(negedge clk);
      if (!seen && !drv_lo) lows++;
      if (drv_lo) seen = 1;
      if (busy) busys++;
      if (drv_hi) hi_on++;
    end
    chk({req, " fall gap"}, lows, d);
    chk({req, " fall hi stays off"}, hi_on, 0);
    chk("R8 busy length fall", busys, d);
  endtask

  task automatic t_pass();
    logic [23:0] pat = 24'b0110_1110_0010_1101_0011_1010;
    logic prev = 1'b0;
    int mism = 0;
    dead_cfg = 8'd0;
    for (int i = 23; i >= -1; i--) begin
      @(negedge clk);
      if (i < 23) begin
        if (drv_hi !== prev || drv_lo !== ~prev) mism++;
      end
      if (i >= 0) begin
        pwm_in = pat[i];
        prev = pat[i];
      end
    end
    chk("R4 zero setting pass-through", mism, 0);
    @(negedge clk);
    pwm_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pulse(input int d, input int w, input string req);
    int hi_cnt = 0; int lo_low = 0;
    @(negedge clk);
    dead_cfg = d[7:0];
    pwm_in = 1'b1;
    for (int k = 0; k < w + d + 3; k++) begin
      @(negedge clk);
      if (drv_hi) hi_cnt++;
      if (!drv_lo) lo_low++;
      if (k == w - 1) pwm_in = 1'b0;
    end
    chk({req, " hi pulse length"}, hi_cnt, (w > d) ? (w - d) : 0);
    chk({req, " lo low span"}, lo_low, w + d);
  endtask

  task automatic t_kill_sync(input int d);
    int on = 0;
    @(negedge clk);
    kill_async = 1'b0;
    kill_req = 1'b1;
    #1;
    chk("R9 sync kill waits for edge", drv_lo, 1);
    @(negedge clk);
    chk("R9 sync kill lo", drv_lo, 0);
    chk("R9 sync kill hi", drv_hi, 0);
    dead_cfg = d[7:0];
    pwm_in = 1'b1;
    repeat (d + 3) begin
      @(negedge clk);
      on += drv_hi + drv_lo;
    end
    chk("R9 kill blocks edges", on, 0);
    kill_req = 1'b0;
    on = 0;
    repeat (d + 5) begin
      @(negedge clk);
      on += drv_hi + drv_lo;
    end
    chk("R11 stays off after sync release", on, 0);
    gap_fall(d, "R11");
  endtask

  task automatic t_kill_async(input int d);
    int on = 0;
    @(negedge clk);
    kill_async = 1'b1;
    #3 kill_req = 1'b1;
    #1;
    chk("R10 async kill immediate", drv_lo, 0);
    repeat (2) @(negedge clk);
    chk("R10 async kill held hi", drv_hi, 0);
    kill_req = 1'b0;
    repeat (6) begin
      @(negedge clk);
      on += drv_hi + drv_lo;
    end
    chk("R11 stays off after async release", on, 0);
    gap_rise(d, -1, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    gap_rise(1, -1, "R2");
    gap_fall(1, "R3");
    gap_rise(255, -1, "R2");
    gap_fall(255, "R3");
    gap_rise(0, -1, "R2");
    gap_fall(0, "R3");
    gap_rise(6, 1, "R12");
    gap_fall(2, "R3");
    t_pass();
    t_pulse(5, 3, "R5");
    t_pulse(5, 5, "R5");
    t_pulse(5, 6, "R6");
    t_pulse(3, 9, "R6");
    t_kill_sync(2);
    t_kill_async(4);
    chk("R7 outputs never overlap", overlaps, 0);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule